// File: doc/BRIEF.md
# AXI Write Data Beat Generator

This block produces the write data channel of an AXI master for one command at a time. A caller hands it a starting index into a local data memory, a burst length field and a three-bit final-beat strobe code. The block reads one word per beat from a synchronous-read memory, starting at the index and moving up by one word per beat. It presents each word with WDATA, WSTRB and WLAST under VALID/READY flow control. When the last beat has been accepted it signals completion to the caller for one cycle.

The data width is a parameter. At 64 bits a non-zero final-beat code keeps that many low byte lanes. At 32 bits only codes 100, 101 and 110 trim the lanes. At widths above 64 bits the code is expected to be zero and every lane is kept. Address issue, response handling and the memory itself are outside the block.

The controller has five named states. IDLE accepts a command. FETCH issues the memory read. WAIT captures the returned word. SEND holds the beat valid until it is accepted. FINISH raises the completion pulse. The transitions are:
- IDLE→FETCH on command accept.
- FETCH→WAIT always.
- WAIT→SEND always.
- SEND→FETCH on acceptance of a beat that is not the last.
- SEND→FINISH on acceptance of the final beat.
- FINISH→IDLE always.

Top module: `wdgen_top`

## Requirements
- R1: After reset `cmd_ready` is 1 and `wvalid` and `done` are 0. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 from the cycle after acceptance until the block returns to IDLE, which includes every cycle in which `wvalid` is 1.
- R2: A command yields exactly `cmd_len`+1 beats. `wlast` is 1 on the final beat only.
- R3: Beat i carries the memory word at address (`cmd_index` + i) modulo 2^13.
- R4: Every beat other than the final one has all `wstrb` bits set.
- R5: With DW=64, the final beat's `wstrb` is 8'hFF for code 0. For code k from 1 to 7 it is the low k bits set, so code 1 gives 8'h01, code 2 gives 8'h03 and code 7 gives 8'h7F.
- R6: With DW=32, the final beat's `wstrb` is 4'h1 for code 3'b100, 4'h3 for 3'b101 and 4'h7 for 3'b110. Every other code gives 4'hF.
- R7: While `wvalid` is 1 and `wready` is 0, the next cycle keeps `wvalid` at 1 and `wdata`, `wstrb` and `wlast` unchanged.
- R8: `done` is 1 for exactly one cycle per command. That cycle is the one directly after the clock edge that accepts the final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_index | input | 13 | Starting word index in the data memory |
| cmd_len | input | 8 | Beat count minus one |
| cmd_last_code | input | 3 | Final-beat strobe code |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 13 | Memory read address |
| mem_rd_data | input | DW | Read word, valid the cycle after the request |
| wvalid | output | 1 | Write beat valid |
| wready | input | 1 | Write beat accepted |
| wdata | output | DW | Write data |
| wstrb | output | DW/8 | Byte lane enables |
| wlast | output | 1 | Final beat marker |
| done | output | 1 | Data phase complete pulse |

## Verification
The assertions assume the memory returns a word exactly one cycle after a read request and that `cmd_valid` is raised only when a command is intended. They place no rule on how `wready` behaves. The stimulus drives two instances, at 64 and 32 bits, from the same commands. It issues a new command only after both instances have reported completion. It drives `wready` first as constantly high and then from a pseudo-random bit stream, so that beats stall for single and multiple cycles. The command set covers every final-beat code in both widths, a single-beat burst, a 256-beat burst and an index that wraps past the top of the memory.

// File: rtl/wdgen_pkg.sv
package wdgen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_SEND   = 3'd3,
        ST_FINISH = 3'd4
    } wd_state_e;

    localparam int CODE_W = 3;

endpackage

// File: rtl/wdgen_strobe_dec.sv
module wdgen_strobe_dec #(
    parameter int DW     = 64,
    parameter int STRB_W = DW / 8
) (
    input  logic [2:0]        code,
    output logic [STRB_W-1:0] strb
);

    generate
        if (DW == 64) begin : g_w64
            always_comb begin
                if (code == 3'd0) begin
                    strb = '1;
                end else begin
                    strb = STRB_W'((16'd1 << code) - 16'd1);
                end
            end
        end else if (DW == 32) begin : g_w32
            always_comb begin
                unique case (code)
                    3'b100:  strb = STRB_W'(4'h1);
                    3'b101:  strb = STRB_W'(4'h3);
                    3'b110:  strb = STRB_W'(4'h7);
                    default: strb = '1;
                endcase
            end
        end else begin : g_wide
            logic code_unused;
            assign code_unused = ^code;
            assign strb = '1;
        end
    endgenerate

endmodule

// File: rtl/wdgen_beat_track.sv
module wdgen_beat_track #(
    parameter int IDX_W = 13,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [IDX_W-1:0] idx_in,
    input  logic [LEN_W-1:0] len_in,
    output logic [IDX_W-1:0] addr,
    output logic             is_last
);

    logic [LEN_W-1:0] remain_q;
    logic [IDX_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            addr_q   <= '0;
        end else if (load) begin
            remain_q <= len_in;
            addr_q   <= idx_in;
        end else if (advance) begin
            remain_q <= remain_q - 1'b1;
            addr_q   <= addr_q + 1'b1;
        end
    end

    assign addr    = addr_q;
    assign is_last = (remain_q == '0);

endmodule

// File: rtl/wdgen_ctrl.sv
module wdgen_ctrl
    import wdgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_valid,
    input  logic      wready,
    input  logic      is_last,
    output wd_state_e state,
    output logic      cmd_ready,
    output logic      load,
    output logic      rd_en,
    output logic      capture,
    output logic      wvalid,
    output logic      advance,
    output logic      done
);

    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cmd_ready = 1'b0;
        load      = 1'b0;
        rd_en     = 1'b0;
        capture   = 1'b0;
        wvalid    = 1'b0;
        advance   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    load    = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                rd_en   = 1'b1;
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                capture = 1'b1;
                state_d = ST_SEND;
            end
            ST_SEND: begin
                wvalid = 1'b1;
                if (wready) begin
                    advance = 1'b1;
                    state_d = is_last ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FINISH: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/wdgen_top.sv
module wdgen_top
    import wdgen_pkg::*;
#(
    parameter int DW     = 64,
    parameter int IDX_W  = 13,
    parameter int LEN_W  = 8,
    localparam int STRB_W = DW / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [2:0]        cmd_last_code,
    output logic              mem_rd_en,
    output logic [IDX_W-1:0]  mem_rd_addr,
    input  logic [DW-1:0]     mem_rd_data,
    output logic              wvalid,
    input  logic              wready,
    output logic [DW-1:0]     wdata,
    output logic [STRB_W-1:0] wstrb,
    output logic              wlast,
    output logic              done
);

    wd_state_e          state;
    logic               load, capture, advance, is_last;
    logic [2:0]         code_q;
    logic [STRB_W-1:0]  last_strb;
    logic [DW-1:0]      wdata_q;
    logic [STRB_W-1:0]  wstrb_q;
    logic               wlast_q;
    logic               state_unused;

    assign state_unused = ^state;

    wdgen_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .wready    (wready),
        .is_last   (is_last),
        .state     (state),
        .cmd_ready (cmd_ready),
        .load      (load),
        .rd_en     (mem_rd_en),
        .capture   (capture),
        .wvalid    (wvalid),
        .advance   (advance),
        .done      (done)
    );

    wdgen_beat_track #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .idx_in  (cmd_index),
        .len_in  (cmd_len),
        .addr    (mem_rd_addr),
        .is_last (is_last)
    );

    wdgen_strobe_dec #(.DW(DW)) u_strb (
        .code (code_q),
        .strb (last_strb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= cmd_last_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
            wstrb_q <= '0;
            wlast_q <= 1'b0;
        end else if (capture) begin
            wdata_q <= mem_rd_data;
            wstrb_q <= is_last ? last_strb : '1;
            wlast_q <= is_last;
        end
    end

    assign wdata = wdata_q;
    assign wstrb = wstrb_q;
    assign wlast = wlast_q;

endmodule

// File: rtl/wdgen_checker.sv
module wdgen_checker #(
    parameter int DW     = 64,
    parameter int STRB_W = DW / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              mem_rd_en,
    input logic              wvalid,
    input logic              wready,
    input logic [DW-1:0]     wdata,
    input logic [STRB_W-1:0] wstrb,
    input logic              wlast,
    input logic              done
);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wstrb) && $stable(wlast)));

    assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |-> !cmd_ready);

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wvalid && wready && wlast));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_full_strb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && !wlast) |-> (&wstrb));

    assert_read_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (!wvalid && !cmd_ready));

endmodule

bind wdgen_top wdgen_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .mem_rd_en (mem_rd_en),
    .wvalid    (wvalid),
    .wready    (wready),
    .wdata     (wdata),
    .wstrb     (wstrb),
    .wlast     (wlast),
    .done      (done)
);

// File: tb/wdgen_top_test.sv
`timescale 1ns/1ps
module wdgen_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [12:0] cmd_index = '0;
    logic [7:0]  cmd_len = '0;
    logic [2:0]  cmd_code = '0;

    always #2 clk = ~clk;

    logic        rdy_a, rden_a, wv_a, wr_a = 1'b0, wl_a, dn_a;
    logic [12:0] addr_a;
    logic [63:0] rdat_a = '0, wd_a;
    logic [7:0]  ws_a;
    logic        rdy_b, rden_b, wv_b, wr_b = 1'b0, wl_b, dn_b;
    logic [12:0] addr_b;
    logic [31:0] rdat_b = '0, wd_b;
    logic [3:0]  ws_b;

    wdgen_top #(.DW(64)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_a),
        .cmd_index(cmd_index), .cmd_len(cmd_len), .cmd_last_code(cmd_code),
        .mem_rd_en(rden_a), .mem_rd_addr(addr_a), .mem_rd_data(rdat_a),
        .wvalid(wv_a), .wready(wr_a), .wdata(wd_a), .wstrb(ws_a), .wlast(wl_a), .done(dn_a)
    );

    wdgen_top #(.DW(32)) uut_n32 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_b),
        .cmd_index(cmd_index), .cmd_len(cmd_len), .cmd_last_code(cmd_code),
        .mem_rd_en(rden_b), .mem_rd_addr(addr_b), .mem_rd_data(rdat_b),
        .wvalid(wv_b), .wready(wr_b), .wdata(wd_b), .wstrb(ws_b), .wlast(wl_b), .done(dn_b)
    );

    function automatic logic [63:0] patt(input logic [12:0] a);
        return {16'hC0DE ^ {3'b0, a}, 16'hBEEF, 3'b0, a, 16'h1234};
    endfunction

    function automatic logic [7:0] exp_last_strb(input int lane, input logic [2:0] code);
        if (lane == 0) begin
            if (code == 3'd0) return 8'hFF;
            return 8'((16'd1 << code) - 16'd1);
        end
        case (code)
            3'b100:  return 8'h01;
            3'b101:  return 8'h03;
            3'b110:  return 8'h07;
            default: return 8'h0F;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rden_a) rdat_a <= patt(addr_a);
        if (rden_b) rdat_b <= patt(addr_b)[31:0];
    end

    logic [72:0] qa[$];
    logic [72:0] qb[$];
    int  checks = 0, fails = 0, cyc = 0;
    int  dones_a = 0, dones_b = 0;
    bit  pend_a = 0, pend_b = 0;
    bit  running = 0;
    int  stall_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic lane_step(input int lane, input logic v, input logic r, input logic cr,
                             input logic [72:0] got, input logic d);
        logic [72:0] exp;
        bit pend;
        pend = (lane == 0) ? pend_a : pend_b;
        if (pend || d) begin
            checks++;
            if (pend != d) begin
                fails++;
                $display("FAIL R8 lane %0d done got %0b exp %0b", lane, d, pend);
            end
        end
        if (lane == 0) pend_a = 0; else pend_b = 0;
        if (d) begin
            if (lane == 0) dones_a++; else dones_b++;
        end
        if (v) begin
            checks++;
            if (cr) begin
                fails++;
                $display("FAIL R1 lane %0d cmd_ready got 1 exp 0 while wvalid", lane);
            end
            if ((lane == 0 ? qa.size() : qb.size()) == 0) begin
                fails++;
                $display("FAIL R2 lane %0d extra beat got wvalid 1 exp 0", lane);
            end else begin
                exp = (lane == 0) ? qa[0] : qb[0];
                if (got[63:0] !== exp[63:0]) begin
                    fails++;
                    $display("FAIL R3 lane %0d wdata got %h exp %h", lane, got[63:0], exp[63:0]);
                end
                if (got[72] !== exp[72]) begin
                    fails++;
                    $display("FAIL R2 lane %0d wlast got %0b exp %0b", lane, got[72], exp[72]);
                end
                if (got[71:64] !== exp[71:64]) begin
                    fails++;
                    if (!exp[72])
                        $display("FAIL R4 lane %0d wstrb got %h exp %h", lane, got[71:64], exp[71:64]);
                    else if (lane == 0)
                        $display("FAIL R5 lane %0d wstrb got %h exp %h", lane, got[71:64], exp[71:64]);
                    else
                        $display("FAIL R6 lane %0d wstrb got %h exp %h", lane, got[71:64], exp[71:64]);
                end
                if (r) begin
                    if (lane == 0) begin
                        void'(qa.pop_front());
                        if (exp[72]) pend_a = 1;
                    end else begin
                        void'(qb.pop_front());
                        if (exp[72]) pend_b = 1;
                    end
                end
            end
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_a = (stall_mode == 0) ? 1'b1 : lfsr[0];
            wr_b = (stall_mode == 0) ? 1'b1 : lfsr[3];
            lane_step(0, wv_a, wr_a, rdy_a, {wl_a, ws_a, wd_a}, dn_a);
            lane_step(1, wv_b, wr_b, rdy_b, {wl_b, 4'b0, ws_b, 32'b0, wd_b}, dn_b);
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog expired at cycle %0d", cyc);
                $display("[TB] %0d tests run, %0d failed", checks, fails);
                $finish;
            end
        end
    end

    int issued = 0;

    task automatic run_cmd(input logic [12:0] idx, input logic [7:0] len, input logic [2:0] code);
        @(negedge clk);
        checks++;
        if (!(rdy_a && rdy_b)) begin
            fails++;
            $display("FAIL R1 cmd_ready got %0b%0b exp 11 when idle", rdy_a, rdy_b);
        end
        for (int i = 0; i <= int'(len); i++) begin
            logic [12:0] a;
            logic [7:0]  sa, sb;
            a  = idx + 13'(i);
            sa = (i == int'(len)) ? exp_last_strb(0, code) : 8'hFF;
            sb = (i == int'(len)) ? exp_last_strb(1, code) : 8'h0F;
            qa.push_back({i == int'(len), sa, patt(a)});
            qb.push_back({i == int'(len), sb, 32'b0, patt(a)[31:0]});
        end
        cmd_index = idx; cmd_len = len; cmd_code = code; cmd_valid = 1'b1;
        issued++;
        @(negedge clk);
        cmd_valid = 1'b0;
        checks++;
        if (rdy_a || rdy_b) begin
            fails++;
            $display("FAIL R1 cmd_ready after accept got %0b%0b exp 00", rdy_a, rdy_b);
        end
        wait (dones_a == issued && dones_b == issued);
        repeat (3) @(negedge clk);
        checks++;
        if (qa.size() != 0 || qb.size() != 0 || dones_a != issued || dones_b != issued) begin
            fails++;
            $display("FAIL R2 beats left got %0d/%0d exp 0/0", qa.size(), qb.size());
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rdy_a !== 1'b1 || wv_a !== 1'b0 || dn_a !== 1'b0 || rdy_b !== 1'b1 || wv_b !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state got rdy %0b wvalid %0b done %0b exp 1 0 0", rdy_a, wv_a, dn_a);
        end
        rst_n = 1'b1;
        running = 1;
        stall_mode = 0;
        run_cmd(13'd0,    8'd0, 3'd0);
        run_cmd(13'd5,    8'd3, 3'd1);
        run_cmd(13'd100,  8'd7, 3'd2);
        run_cmd(13'd8190, 8'd4, 3'd3);
        run_cmd(13'd17,   8'd2, 3'd4);
        run_cmd(13'd33,   8'd1, 3'd5);
        run_cmd(13'd40,   8'd0, 3'd6);
        run_cmd(13'd50,   8'd2, 3'd7);
        stall_mode = 1;
        run_cmd(13'd200,  8'd15, 3'd0);
        run_cmd(13'd300,  8'd3,  3'd5);
        run_cmd(13'd12,   8'd255, 3'd7);
        run_cmd(13'd8191, 8'd2,  3'd6);
        run_cmd(13'd77,   8'd0,  3'd4);
        run_cmd(13'd900,  8'd5,  3'd1);
        running = 0;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule